// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a stereo serial audio stream made of a bit clock, a left/right word clock and one data line, and turns it into a pair of signed 24-bit sample words with a one-cycle valid strobe. The three serial inputs are not used as clocks. A faster system clock samples them through two-stage synchronizers, and every rising edge of the bit clock is found by edge detection. Each word-clock change closes one channel half-period. The bits captured in that half-period become that channel's word.

A 3-bit format code picks the framing and the word length together. The framing can be right-justified, left-justified or I2S, and the length can be 16, 20 or 24 bits. A polarity input chooses which word-clock level means left for the two non-I2S framings. Shorter words are widened to 24 bits by appending zero LSBs. A half-period with too few bit-clock slots for the chosen format raises a configuration error flag. The receiver still delivers whatever bits arrived in that half-period.

Top module: `aud_ser_rx`

## Requirements
- R1: Data and word-clock levels are taken at each rising edge of the bit clock. A change of the word-clock level between two rising edges closes the current channel half-period. The bit taken at the edge that shows the change is slot 0 of the new half-period.
- R2: Codes 000, 001 and 010 select right-justified framing with 16, 20 and 24 bits. The LSB is the last slot before the closing word-clock change. Slots before the MSB have no effect on the output.
- R3: Code 011 selects 24-bit left-justified framing. The MSB is slot 0, and slots after the LSB have no effect on the output.
- R4: Codes 100 and 101 select 16-bit and 24-bit I2S framing. The MSB is slot 1. A low word clock means left whatever the polarity input is.
- R5: For codes 000 to 011, polarity input 0 makes a high word clock left, and polarity input 1 makes a low word clock left.
- R6: Every output word is 24-bit two's complement. A 16-bit or 20-bit sample sits in the top bits, with zero LSBs below it.
- R7: The valid strobe is high for exactly one system clock per stereo frame, after a right half-period that followed a left half-period. Both output words update in that same cycle and hold their values at all other times.
- R8: The valid strobe and the new words appear at the third rising system clock edge after the rising bit-clock edge that closes the right half-period.
- R9: A half-period needs enough slots for the format: N slots for right-justified or left-justified framing, and N+1 for I2S. If it has fewer, the error flag is 1 after that half-period closes. Right-justified framing then keeps the low bits that arrived, and left-justified framing keeps the high bits that arrived.
- R10: Codes 110 and 111 are reserved. They never produce a valid strobe, and they set the error flag when a half-period closes.
- R11: Bit-clock rates of 32, 48 and 64 slots per frame are all received correctly.
- R12: During reset, both output words are zero and the valid strobe and the error flag are low.
- R13: After reset, the half-period in progress has no known start and produces no output. The first valid strobe comes only from a frame whose left half-period began at an observed word-clock change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock |
| lrclk | input | 1 | Left/right word clock at the sample rate |
| sdin | input | 1 | Serial data, MSB first |
| fmt_code | input | 3 | Framing and word-length selector |
| lr_swap | input | 1 | Word-clock polarity for non-I2S framings |
| left_smp | output | 24 | Left channel sample |
| right_smp | output | 24 | Right channel sample |
| smp_valid | output | 1 | One-cycle strobe: a new stereo pair is on the outputs |
| cfg_err | output | 1 | Last closed half-period was too short, or the code is reserved |

## Verification
The only result with a deadline is the frame result. Valid, both words and the error flag are due three system clock edges after the bench raises the bit clock in the slot that carries the word-clock change closing a right half-period. Two of those edges are the synchronizer and the third is the output register. The bench drives every input change at a falling system clock edge. After that closing bit-clock edge it checks that valid is still low one sample after the second rising edge, then checks every result one sample after the third, then checks that valid has dropped after the fourth. A result that comes a cycle early or late, or a strobe that lasts too long, is therefore caught.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  parameter int SMP_W  = 24;
  parameter int LEN_W  = $clog2(SMP_W + 1);
  parameter int SLOT_W = 6;

  typedef logic [LEN_W-1:0]  len_t;
  typedef logic [SLOT_W-1:0] slot_t;

  typedef enum logic [1:0] {
    STY_RJ  = 2'd0,
    STY_LJ  = 2'd1,
    STY_I2S = 2'd2,
    STY_BAD = 2'd3
  } style_e;
endpackage

// File: rtl/aud_rx_edge.sv
module aud_rx_edge #(
  parameter int N_SIG       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SIG-1:0] raw,
  output logic [N_SIG-1:0] syn,
  output logic             rise
);
  logic prev_q;

  for (genvar g = 0; g < N_SIG; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] st_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= {st_q[SYNC_STAGES-2:0], raw[g]};
    end
    assign syn[g] = st_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= syn[0];
  end

  assign rise = syn[0] & ~prev_q;
endmodule

// File: rtl/aud_rx_fmt.sv
module aud_rx_fmt
  import aud_rx_pkg::*;
(
  input  logic [2:0] code,
  input  logic       swap,
  input  logic       lvl,
  output style_e     style,
  output len_t       len,
  output logic       lvl_is_left
);
  always_comb begin
    unique case (code)
      3'b000:  begin style = STY_RJ;  len = len_t'(16); end
      3'b001:  begin style = STY_RJ;  len = len_t'(20); end
      3'b010:  begin style = STY_RJ;  len = len_t'(24); end
      3'b011:  begin style = STY_LJ;  len = len_t'(24); end
      3'b100:  begin style = STY_I2S; len = len_t'(16); end
      3'b101:  begin style = STY_I2S; len = len_t'(24); end
      default: begin style = STY_BAD; len = len_t'(16); end
    endcase
    lvl_is_left = (style == STY_I2S) ? ~lvl : (lvl ^ swap);
  end
endmodule

// File: rtl/aud_rx_half.sv
module aud_rx_half
  import aud_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             din,
  input  logic             lvl,
  input  style_e           style,
  input  len_t             len,
  output logic             done,
  output logic             done_lvl,
  output logic             done_short,
  output logic [SMP_W-1:0] done_word
);
  logic             started_q, started_d;
  logic             synced_q, synced_d;
  logic             lvl_q, lvl_d;
  slot_t            cnt_q, cnt_d;
  logic [SMP_W-1:0] sh_q, sh_d;
  logic [SMP_W-1:0] acc_q, acc_d;
  logic             trans;
  slot_t            idx;
  slot_t            need;
  len_t             shamt;

  always_comb begin
    trans     = started_q && (lvl != lvl_q);
    idx       = trans ? '0 : cnt_q;
    started_d = started_q;
    synced_d  = synced_q;
    lvl_d     = lvl_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    acc_d     = acc_q;
    if (en) begin
      started_d = 1'b1;
      lvl_d     = lvl;
      if (trans) synced_d = 1'b1;
      cnt_d = (idx == '1) ? idx : idx + 1'b1;
      sh_d  = trans ? {{(SMP_W-1){1'b0}}, din} : {sh_q[SMP_W-2:0], din};
      acc_d = trans ? '0 : acc_q;
      for (int k = 0; k < SMP_W; k++) begin
        if (style == STY_LJ && int'(idx) == k && k < int'(len))
          acc_d[SMP_W-1-k] = din;
        if (style == STY_I2S && int'(idx) == k + 1 && k < int'(len))
          acc_d[SMP_W-1-k] = din;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      synced_q  <= 1'b0;
      lvl_q     <= 1'b0;
      cnt_q     <= '0;
      sh_q      <= '0;
      acc_q     <= '0;
    end else if (en) begin
      started_q <= started_d;
      synced_q  <= synced_d;
      lvl_q     <= lvl_d;
      cnt_q     <= cnt_d;
      sh_q      <= sh_d;
      acc_q     <= acc_d;
    end
  end

  always_comb begin
    shamt      = len_t'(SMP_W) - len;
    need       = slot_t'(len) + slot_t'(style == STY_I2S);
    done       = en && trans && synced_q;
    done_lvl   = lvl_q;
    done_short = (cnt_q < need);
    done_word  = (style == STY_RJ) ? (sh_q << shamt) : acc_q;
  end
endmodule

// File: rtl/aud_ser_rx.sv
module aud_ser_rx
  import aud_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk,
  input  logic             lrclk,
  input  logic             sdin,
  input  logic [2:0]       fmt_code,
  input  logic             lr_swap,
  output logic [SMP_W-1:0] left_smp,
  output logic [SMP_W-1:0] right_smp,
  output logic             smp_valid,
  output logic             cfg_err
);
  localparam int N_IN = 3;

  logic [1:0]       rs_q;
  logic             rst_i;
  logic [N_IN-1:0]  syn;
  logic             bit_rise;
  style_e           style;
  len_t             len;
  logic             ended_left;
  logic             half_done, half_lvl, half_short;
  logic [SMP_W-1:0] half_word;

  logic [SMP_W-1:0] lp_q, lp_d, lo_q, lo_d, ro_q, ro_d;
  logic             hl_q, hl_d, v_q, v_d, e_q, e_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  aud_rx_edge #(.N_SIG(N_IN), .SYNC_STAGES(2)) u_edge (
    .clk(clk), .rst_n(rst_i), .raw({sdin, lrclk, bclk}),
    .syn(syn), .rise(bit_rise)
  );

  aud_rx_fmt u_fmt (
    .code(fmt_code), .swap(lr_swap), .lvl(half_lvl),
    .style(style), .len(len), .lvl_is_left(ended_left)
  );

  aud_rx_half u_half (
    .clk(clk), .rst_n(rst_i), .en(bit_rise), .din(syn[2]), .lvl(syn[1]),
    .style(style), .len(len), .done(half_done), .done_lvl(half_lvl),
    .done_short(half_short), .done_word(half_word)
  );

  always_comb begin
    lp_d = lp_q;
    hl_d = hl_q;
    lo_d = lo_q;
    ro_d = ro_q;
    e_d  = e_q;
    v_d  = 1'b0;
    if (half_done) begin
      e_d = (style == STY_BAD) || half_short;
      if (style != STY_BAD) begin
        if (ended_left) begin
          lp_d = half_word;
          hl_d = 1'b1;
        end else if (hl_q) begin
          lo_d = lp_q;
          ro_d = half_word;
          v_d  = 1'b1;
          hl_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      lp_q <= '0;
      lo_q <= '0;
      ro_q <= '0;
      hl_q <= 1'b0;
      v_q  <= 1'b0;
      e_q  <= 1'b0;
    end else begin
      lp_q <= lp_d;
      lo_q <= lo_d;
      ro_q <= ro_d;
      hl_q <= hl_d;
      v_q  <= v_d;
      e_q  <= e_d;
    end
  end

  assign left_smp  = lo_q;
  assign right_smp = ro_q;
  assign smp_valid = v_q;
  assign cfg_err   = e_q;
endmodule

// File: rtl/aud_ser_rx_chk.sv
module aud_ser_rx_chk
  import aud_rx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       fmt_code,
  input logic             smp_valid,
  input logic [SMP_W-1:0] left_smp,
  input logic [SMP_W-1:0] right_smp,
  input logic             bit_rise
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid); // R7

  AST_HOLD_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> ($stable(left_smp) && $stable(right_smp))); // R7

  AST_VALID_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(bit_rise)); // R8

  AST_NO_RESERVED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> ($past(fmt_code[2:1]) != 2'b11)); // R10

  AST_ZERO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && $past(fmt_code) == 3'b000) |-> (right_smp[SMP_W-17:0] == '0)); // R6
endmodule

bind aud_ser_rx aud_ser_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fmt_code(fmt_code), .smp_valid(smp_valid),
  .left_smp(left_smp), .right_smp(right_smp), .bit_rise(bit_rise)
);

// File: tb/aud_ser_rx_tb.sv
module aud_ser_rx_tb;
  localparam int H = 4;

  logic        clk = 1'b0;
  logic        rst_n, bclk, lrclk, sdin, lr_swap;
  logic [2:0]  fmt_code;
  logic [23:0] left_smp, right_smp;
  logic        smp_valid, cfg_err;

  int n_chk = 0;
  int n_bad = 0;

  bit          pend_on, pend_vld, pe_err;
  logic [23:0] pe_l, pe_r;
  string       pe_tag;

  always #2 clk = ~clk;

  aud_ser_rx u_dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdin(sdin),
    .fmt_code(fmt_code), .lr_swap(lr_swap), .left_smp(left_smp),
    .right_smp(right_smp), .smp_valid(smp_valid), .cfg_err(cfg_err)
  );

  task automatic chk(bit ok, string tag, string what, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Called right after the bit clock rises in a closing slot (R8 timing).
  task automatic close_check();
    @(posedge clk); @(posedge clk); #1;
    chk(smp_valid == 1'b0, "R8", "valid early", 24'(smp_valid), 24'd0);
    @(posedge clk); #1;
    chk(smp_valid == pend_vld, pe_tag, "valid", 24'(smp_valid), 24'(pend_vld));
    chk(cfg_err == pe_err, pe_tag, "cfg_err", 24'(cfg_err), 24'(pe_err));
    if (pend_vld) begin
      chk(left_smp == pe_l, pe_tag, "left", left_smp, pe_l);
      chk(right_smp == pe_r, pe_tag, "right", right_smp, pe_r);
    end
    @(posedge clk); #1;
    chk(smp_valid == 1'b0, "R7", "valid width", 24'(smp_valid), 24'd0);
    @(negedge clk);
    pend_on = 1'b0;
  endtask

  // R1: level and data change while the bit clock is low, taken at its rise.
  task automatic send_bit(logic lv, logic d, bit do_close);
    @(negedge clk);
    bclk = 1'b0; lrclk = lv; sdin = d;
    repeat (H - 1) @(negedge clk);
    bclk = 1'b1;
    if (do_close) close_check();
    else repeat (H - 1) @(negedge clk);
  endtask

  function automatic logic half_bit(int sty, int n, int b, logic [23:0] w, int i);
    logic junk = (i % 2 == 0);
    if (sty == 0) return (i >= b - n) ? w[n - 1 - (i - (b - n))] : junk;
    if (sty == 1) return (i < n) ? w[n - 1 - i] : junk;
    return (i >= 1 && i <= n) ? w[n - i] : junk;
  endfunction

  function automatic logic [23:0] exp_word(int sty, int n, int b, logic [23:0] w);
    int need = n + ((sty == 2) ? 1 : 0);
    int got  = (sty == 2) ? b - 1 : b;
    if (b >= need) return w << (24 - n);
    if (sty == 0) return (w & ((24'd1 << b) - 24'd1)) << (24 - n);
    return ((w >> (n - got)) << (n - got)) << (24 - n);
  endfunction

  task automatic send_frame(int sty, int n, int b, logic lvl_l, logic [23:0] l, logic [23:0] r);
    for (int i = 0; i < b; i++) send_bit(lvl_l, half_bit(sty, n, b, l, i), (i == 0) && pend_on);
    for (int i = 0; i < b; i++) send_bit(~lvl_l, half_bit(sty, n, b, r, i), 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bclk = 1'b0; lrclk = 1'b0; sdin = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_case(string tag, logic [2:0] code, bit swp, int sty, int n, int b,
                          logic [23:0] l1, logic [23:0] r1, logic [23:0] l2, logic [23:0] r2,
                          bit reserved);
    logic lvl_l;
    bit   short_h;
    do_reset();
    fmt_code = code; lr_swap = swp;
    lvl_l   = (sty == 2) ? 1'b0 : ~swp;
    short_h = b < n + ((sty == 2) ? 1 : 0);
    for (int i = 0; i < 3; i++) send_bit(~lvl_l, 1'b1, 1'b0);
    pend_on = 1'b1; pend_vld = 1'b0; pe_err = 1'b0; pe_tag = "R13";
    send_frame(sty, n, b, lvl_l, l1, r1);
    pend_on = 1'b1; pend_vld = !reserved; pe_err = reserved || short_h; pe_tag = tag;
    pe_l = exp_word(sty, n, b, l1); pe_r = exp_word(sty, n, b, r1);
    send_frame(sty, n, b, lvl_l, l2, r2);
    pend_on = 1'b1;
    pe_l = exp_word(sty, n, b, l2); pe_r = exp_word(sty, n, b, r2);
    send_bit(lvl_l, 1'b0, 1'b1);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    fmt_code = 3'b000; lr_swap = 1'b0; pend_on = 1'b0;
    rst_n = 1'b0; bclk = 1'b0; lrclk = 1'b0; sdin = 1'b0;
    repeat (3) @(negedge clk);
    chk(left_smp == 24'd0, "R12", "left in reset", left_smp, 24'd0);
    chk(right_smp == 24'd0, "R12", "right in reset", right_smp, 24'd0);
    chk(smp_valid == 1'b0, "R12", "valid in reset", 24'(smp_valid), 24'd0);
    chk(cfg_err == 1'b0, "R12", "err in reset", 24'(cfg_err), 24'd0);
    // R2 / R6 / R11: right-justified lengths at 64 and 48 slots
    run_case("R2", 3'b000, 1'b0, 0, 16, 32, 24'h8001, 24'h7ffe, 24'h1234, 24'hfedc, 1'b0);
    run_case("R2", 3'b001, 1'b0, 0, 20, 24, 24'h80001, 24'h5a5a5, 24'h0000f, 24'hfffff, 1'b0);
    run_case("R2", 3'b010, 1'b0, 0, 24, 32, 24'h800001, 24'h123456, 24'h7fffff, 24'hc0ffee, 1'b0);
    // R3: left-justified, 48 slots
    run_case("R3", 3'b011, 1'b0, 1, 24, 24, 24'habcdef, 24'h000001, 24'h800000, 24'h654321, 1'b0);
    // R4: I2S, polarity input must not matter
    run_case("R4", 3'b100, 1'b0, 2, 16, 24, 24'h8000, 24'h0001, 24'hbeef, 24'h7f00, 1'b0);
    run_case("R4", 3'b101, 1'b1, 2, 24, 32, 24'h123abc, 24'hf00001, 24'h800000, 24'h7fffff, 1'b0);
    // R5 / R11: swapped polarity, 32 slots per frame
    run_case("R5", 3'b000, 1'b1, 0, 16, 16, 24'hc001, 24'h3ffe, 24'h0f0f, 24'hf0f0, 1'b0);
    // R9: 24-bit words with only 16 slots per half
    run_case("R9", 3'b010, 1'b0, 0, 24, 16, 24'h12abcd, 24'hfe8001, 24'h00ffff, 24'h7f1234, 1'b0);
    run_case("R9", 3'b011, 1'b0, 1, 24, 16, 24'h12abcd, 24'hfe8001, 24'h00ffff, 24'h7f1234, 1'b0);
    // R10: reserved code
    run_case("R10", 3'b110, 1'b0, 0, 16, 32, 24'h1111, 24'h2222, 24'h3333, 24'h4444, 1'b1);
    summary();
    $finish;
  end
endmodule